// File: doc/BRIEF.md
# Bus Idle-Time Transmit Gate

This block sits in front of the transmitter of a single-wire, open-drain control bus and decides when that transmitter may start a new message. It counts how long the bus has stayed high (idle), in units of half a nominal bit period marked by an input tick. Once the required idle time has passed and a start request is waiting, it grants the transmitter a one-cycle permission pulse.

The required idle time comes from a 3-bit code. A non-zero code n asks for 2n − 1 half-bit ticks, which is n − 0.5 bit periods. A zero code picks a default that depends on what last happened on the bus: a fresh initiator waits longest, a node that just completed its own transmission waits less, and a retry after a failed attempt waits least. A start-option input chooses whether the idle count restarts on the software start request or automatically at the end of each message on the bus.

Top module: `bus_idle_gate`

## Requirements
- R1: With sft_code = n for n in 1..7, tx_permit pulses once 2n − 1 half_tick pulses have been seen with bus_level high after the count restarted, and not before.
- R2: With sft_code = 0 and no message ended since reset, or when the last end-of-message had eom_own = 0, the threshold is 14 ticks.
- R3: With sft_code = 0, after an eom_pulse with eom_own = 1, the threshold is 10 ticks.
- R4: With sft_code = 0, after a tx_fail pulse, the threshold is 6 ticks.
- R5: With auto_start = 0, som_req restarts the idle count from zero, and eom_pulse and tx_fail do not restart it.
- R6: With auto_start = 1, eom_pulse or tx_fail restarts the idle count from zero, and som_req only marks a request pending without restarting the count.
- R7: bus_level low in any cycle clears the idle count, so the full threshold must pass again after the bus returns high.
- R8: tx_permit is high for exactly one cycle per request, only while a request was pending in the previous cycle, and rises in the second clock edge after the tick that completes the threshold.
- R9: som_req sets start_pending in the next cycle. tx_ack without som_req clears it in the next cycle. When som_req and tx_ack arrive in the same cycle, the request stays pending and may be granted again.
- R10: A synchronous reset (rst high at a clock edge) clears tx_permit, start_pending, the idle count and the context, which returns to the fresh-initiator case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sft_code | input | 3 | Idle-time code; 0 selects the context default |
| auto_start | input | 1 | 0: count restarts on som_req; 1: count restarts at end of message |
| som_req | input | 1 | Software start-of-message request strobe |
| eom_pulse | input | 1 | End of a message on the bus (sent or received) |
| eom_own | input | 1 | Qualifies eom_pulse: 1 when the finished message was this node's own successful send |
| tx_fail | input | 1 | Pulse when this node's transmit attempt failed |
| tx_ack | input | 1 | Transmitter accepts the pending request |
| half_tick | input | 1 | One pulse per half nominal bit period |
| bus_level | input | 1 | Sampled bus line (1 = idle high) |
| tx_permit | output | 1 | One-cycle permission to begin transmitting |
| start_pending | output | 1 | A start request is waiting |

## Verification
The two functions that can fall in the same cycle are the arrival of a new start request and the acknowledgment of the previous one. The bench provokes this in auto-start mode right after a grant, with the idle count already above threshold. It judges the case by requiring start_pending to stay high and exactly one further permit pulse to follow. It also sweeps every non-zero code and all three default contexts, counting permit pulses after each single tick against 2n − 1 or the context default.

// File: rtl/bus_idle_pkg.sv
package bus_idle_pkg;
  typedef enum logic [1:0] {
    CTX_FRESH   = 2'd0,
    CTX_OWN_TX  = 2'd1,
    CTX_RETRY   = 2'd2
  } idle_ctx_e;

  // Ticks needed for a non-zero code n: 2n - 1 half-bit ticks.
  function automatic int unsigned ticks_for_code(input int unsigned n);
    return (2 * n) - 1;
  endfunction
endpackage

// File: rtl/bus_idle_context.sv
module bus_idle_context
  import bus_idle_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      eom_pulse,
  input  logic      eom_own,
  input  logic      tx_fail,
  output idle_ctx_e ctx
);
  always_ff @(posedge clk) begin
    if (rst)            ctx <= CTX_FRESH;
    else if (tx_fail)   ctx <= CTX_RETRY;
    else if (eom_pulse) ctx <= eom_own ? CTX_OWN_TX : CTX_FRESH;
  end
endmodule

// File: rtl/bus_idle_threshold.sv
module bus_idle_threshold
  import bus_idle_pkg::*;
#(
  parameter int CODE_W    = 3,
  parameter int CNT_W     = 4,
  parameter int DEF_FRESH = 14,
  parameter int DEF_OWN   = 10,
  parameter int DEF_RETRY = 6
) (
  input  logic [CODE_W-1:0] code,
  input  idle_ctx_e         ctx,
  output logic [CNT_W-1:0]  thr
);
  localparam int NCODES = 1 << CODE_W;

  logic [CNT_W-1:0] prog_tbl [NCODES];

  for (genvar i = 0; i < NCODES; i++) begin : g_tbl
    if (i == 0) begin : g_zero
      assign prog_tbl[i] = '0;
    end else begin : g_prog
      assign prog_tbl[i] = CNT_W'(ticks_for_code(i));
    end
  end

  always_comb begin
    if (code != '0) begin
      thr = prog_tbl[code];
    end else begin
      unique case (ctx)
        CTX_OWN_TX: thr = CNT_W'(DEF_OWN);
        CTX_RETRY:  thr = CNT_W'(DEF_RETRY);
        default:    thr = CNT_W'(DEF_FRESH);
      endcase
    end
  end
endmodule

// File: rtl/bus_idle_counter.sv
module bus_idle_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             half_tick,
  input  logic             bus_level,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || restart || !bus_level)          count <= '0;
    else if (half_tick && count != CNT_MAX)    count <= count + 1'b1;
  end
endmodule

// File: rtl/bus_idle_grant.sv
module bus_idle_grant (
  input  logic clk,
  input  logic rst,
  input  logic som_req,
  input  logic tx_ack,
  input  logic reached,
  output logic tx_permit,
  output logic start_pending
);
  logic granted;
  logic fire;

  assign fire = start_pending && !granted && reached && !tx_ack && !som_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_pending <= 1'b0;
      granted       <= 1'b0;
      tx_permit     <= 1'b0;
    end else begin
      tx_permit <= fire;
      if (som_req)     start_pending <= 1'b1;
      else if (tx_ack) start_pending <= 1'b0;
      if (fire)                   granted <= 1'b1;
      else if (som_req || tx_ack) granted <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_idle_gate.sv
module bus_idle_gate
  import bus_idle_pkg::*;
#(
  parameter int CODE_W    = 3,
  parameter int CNT_W     = 4,
  parameter int DEF_FRESH = 14,
  parameter int DEF_OWN   = 10,
  parameter int DEF_RETRY = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] sft_code,
  input  logic              auto_start,
  input  logic              som_req,
  input  logic              eom_pulse,
  input  logic              eom_own,
  input  logic              tx_fail,
  input  logic              tx_ack,
  input  logic              half_tick,
  input  logic              bus_level,
  output logic              tx_permit,
  output logic              start_pending
);
  idle_ctx_e        ctx;
  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] count;
  logic             restart;

  assign restart = auto_start ? (eom_pulse || tx_fail) : som_req;

  bus_idle_context u_ctx (
    .clk(clk), .rst(rst), .eom_pulse(eom_pulse), .eom_own(eom_own),
    .tx_fail(tx_fail), .ctx(ctx)
  );

  bus_idle_threshold #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .DEF_FRESH(DEF_FRESH),
    .DEF_OWN(DEF_OWN), .DEF_RETRY(DEF_RETRY)
  ) u_thr (
    .code(sft_code), .ctx(ctx), .thr(thr)
  );

  bus_idle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart), .half_tick(half_tick),
    .bus_level(bus_level), .count(count)
  );

  bus_idle_grant u_grant (
    .clk(clk), .rst(rst), .som_req(som_req), .tx_ack(tx_ack),
    .reached(count >= thr), .tx_permit(tx_permit),
    .start_pending(start_pending)
  );
endmodule

// File: rtl/bus_idle_gate_chk.sv
module bus_idle_gate_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] sft_code,
  input logic              auto_start,
  input logic              som_req,
  input logic              tx_ack,
  input logic              bus_level,
  input logic              tx_permit,
  input logic              start_pending
);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_permit |=> !tx_permit);

  a_r8_needs_pending: assert property (@(posedge clk) disable iff (rst)
    tx_permit |-> $past(start_pending));

  a_r7_low_blocks: assert property (@(posedge clk) disable iff (rst)
    !bus_level |-> ##2 !tx_permit);

  a_r5_som_restarts: assert property (@(posedge clk) disable iff (rst)
    (som_req && !auto_start) |-> ##2 !tx_permit);

  a_r9_som_sets: assert property (@(posedge clk) disable iff (rst)
    som_req |=> start_pending);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (tx_ack && !som_req) |=> !start_pending);

  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (!tx_permit && !start_pending));
endmodule

bind bus_idle_gate bus_idle_gate_chk #(.CODE_W(CODE_W)) chk (.*);

// File: tb/bus_idle_gate_test.sv
module bus_idle_gate_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sft_code = 3'd0;
  logic       auto_start = 1'b0;
  logic       som_req = 1'b0;
  logic       eom_pulse = 1'b0;
  logic       eom_own = 1'b0;
  logic       tx_fail = 1'b0;
  logic       tx_ack = 1'b0;
  logic       half_tick = 1'b0;
  logic       bus_level = 1'b1;
  logic       tx_permit;
  logic       start_pending;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_idle_gate uut (
    .clk(clk), .rst(rst), .sft_code(sft_code), .auto_start(auto_start),
    .som_req(som_req), .eom_pulse(eom_pulse), .eom_own(eom_own),
    .tx_fail(tx_fail), .tx_ack(tx_ack), .half_tick(half_tick),
    .bus_level(bus_level), .tx_permit(tx_permit),
    .start_pending(start_pending)
  );

  always @(negedge clk) if (tx_permit === 1'b1) pulses++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe(input bit s, input bit e, input bit own, input bit f, input bit a);
    @(posedge clk); #1;
    som_req = s; eom_pulse = e; eom_own = own; tx_fail = f; tx_ack = a;
    @(posedge clk); #1;
    som_req = 0; eom_pulse = 0; eom_own = 0; tx_fail = 0; tx_ack = 0;
    cyc(2);
  endtask

  task automatic give_tick();
    @(posedge clk); #1 half_tick = 1'b1;
    @(posedge clk); #1 half_tick = 1'b0;
    cyc(3);
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(1);
  endtask

  // Deliver need+1 ticks; permit must appear exactly at tick 'need'.
  task automatic run_expect(input int need, input string tag);
    int base;
    int exp;
    base = pulses;
    for (int k = 1; k <= need + 1; k++) begin
      give_tick();
      exp = (k >= need) ? 1 : 0;
      check((pulses - base) == exp, tag, pulses - base, exp);
    end
  endtask

  task automatic finish_report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_report();
    end
  end

  initial begin
    do_reset();
    // R10: reset state
    check(tx_permit == 1'b0, "R10 permit after reset", tx_permit, 0);
    check(start_pending == 1'b0, "R10 pending after reset", start_pending, 0);

    // R1: sweep all non-zero codes in manual mode
    for (int n = 1; n <= 7; n++) begin
      do_reset();
      sft_code = 3'(n);
      strobe(1, 0, 0, 0, 0);
      check(start_pending == 1'b1, "R9 som sets pending", start_pending, 1);
      run_expect(2 * n - 1, "R1 code threshold");
      strobe(0, 0, 0, 0, 1);
      check(start_pending == 1'b0, "R9 ack clears pending", start_pending, 0);
    end

    // R2/R3/R4: defaults chosen by context
    do_reset();
    sft_code = 3'd0;
    strobe(1, 0, 0, 0, 0);
    run_expect(14, "R2 fresh default");
    strobe(0, 0, 0, 0, 1);
    strobe(0, 1, 1, 0, 0);
    strobe(1, 0, 0, 0, 0);
    run_expect(10, "R3 after own send");
    strobe(0, 0, 0, 0, 1);
    strobe(0, 0, 0, 1, 0);
    strobe(1, 0, 0, 0, 0);
    run_expect(6, "R4 retry default");
    strobe(0, 0, 0, 0, 1);
    strobe(0, 1, 0, 0, 0);
    strobe(1, 0, 0, 0, 0);
    run_expect(14, "R2 after received message");
    strobe(0, 0, 0, 0, 1);

    // R7: bus low mid-count restarts the count
    do_reset();
    sft_code = 3'd3;
    strobe(1, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) give_tick();
    @(posedge clk); #1 bus_level = 1'b0;
    @(posedge clk); #1 bus_level = 1'b1;
    cyc(2);
    run_expect(5, "R7 bus low restart");
    strobe(0, 0, 0, 0, 1);

    // R5: manual mode, end of message does not restart the count
    do_reset();
    sft_code = 3'd3;
    strobe(1, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) give_tick();
    strobe(0, 1, 0, 0, 0);
    run_expect(2, "R5 eom ignored in manual mode");
    strobe(0, 0, 0, 0, 1);

    // R6: auto mode, eom restarts; som does not
    do_reset();
    auto_start = 1'b1;
    sft_code = 3'd2;
    strobe(0, 1, 1, 0, 0);
    for (int k = 0; k < 2; k++) give_tick();
    strobe(1, 0, 0, 0, 0);
    run_expect(1, "R6 som keeps count in auto mode");

    // R9: som and ack in the same cycle keep the request pending
    begin
      int base;
      base = pulses;
      strobe(1, 0, 0, 0, 1);
      check(start_pending == 1'b1, "R9 som with ack keeps pending", start_pending, 1);
      check((pulses - base) == 1, "R9 regrant after som with ack", pulses - base, 1);
      cyc(4);
      check((pulses - base) == 1, "R8 single regrant", pulses - base, 1);
    end
    strobe(0, 0, 0, 0, 1);
    check(start_pending == 1'b0, "R9 ack clears pending", start_pending, 0);

    // R6: auto mode, tx_fail restarts the count with retry default
    sft_code = 3'd0;
    strobe(0, 0, 0, 1, 0);
    strobe(1, 0, 0, 0, 0);
    run_expect(6, "R6 fail restart in auto mode");
    strobe(0, 0, 0, 0, 1);

    // R10: reset mid-count clears pending and count
    auto_start = 1'b0;
    sft_code = 3'd4;
    strobe(1, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) give_tick();
    do_reset();
    check(start_pending == 1'b0, "R10 reset clears pending", start_pending, 0);
    sft_code = 3'd1;
    strobe(1, 0, 0, 0, 0);
    run_expect(1, "R10 count cleared by reset");

    done = 1'b1;
    finish_report();
  end
endmodule